// File: doc/BRIEF.md
# Slot-queued SPI master

The block is an SPI master for a register-programmed host. Software fills a transmit RAM and a per-slot command RAM, sets a first-slot pointer and a last-slot pointer, and sets a start bit. The engine then runs every slot from the first to the last with no further help from software. For each slot it drives the slot's chip-select pattern, shifts the transmit byte out in SPI mode 3, and stores the returned byte in receive RAM. When the last slot finishes, it raises a done status bit and, if enabled, an interrupt request.

Each slot's command byte decides two things. Its low field picks which peripheral selects go active. Its continue bit decides whether those selects stay active after the slot. This lets one long peripheral transaction span several slots, or even several queue runs.

The host port is a single-cycle register bus. Writes take effect at the clock edge. Read data is combinational from the address. Data is 8 bits wide and addresses are word addresses.

Top module: `slotq_spi_master`

## Requirements
- R1: After reset, sck_o is 1, all of cs_n_o are 1, and irq_o is 0. CTRL (addr 0x00), STATUS (0x01) and the pointers read 0. DIV (0x04) reads 8.
- R2: A write of a value below 8 to DIV stores 8. Any other value is stored as written.
- R3: The serial clock idles high with a period of 2*DIV system clocks. mosi_o changes only on a falling sck edge. miso_i is sampled on the rising edge. Bits go most significant first.
- R4: A run covers the slots from QSTART (0x02) to QEND (0x03) inclusive, and wraps from slot 15 to slot 0. A slot's transmit byte comes from TX word 0x20+2*slot. Its received byte goes to RX word 0x40+2*slot+1. Even RX words are never written. Command bytes live at 0x60+slot.
- R5: While a slot shifts, cs_n_o equals bits 3:0 of its command byte (active low). If command bit 7 is 0, all selects go high after the slot. If bit 7 is 1, the pattern is held, including past the end of the run.
- R6: Writing CTRL with bit 6 set while idle starts a run. Bit 6 reads 1 until the run ends. STATUS bit 0 becomes 1 exactly N*(1+16*DIV) cycles after the start write, for N slots. At that same point, CTRL bit 6 returns to 0.
- R7: Writing STATUS with bit 0 at 0 clears done. If a completion lands on the same edge as that write, done stays 1.
- R8: irq_o is STATUS bit 0 AND CTRL bit 5.
- R9: A CTRL write with bit 6 set during a run does not restart, lengthen or shorten it.
- R10: LOCK (0x06, bit 0) and MODE (0x05, bits 5:0) read back what was written and do not change the serial behaviour.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_req_i | input | 1 | Bus access strobe |
| bus_we_i | input | 1 | Write when 1, read when 0 |
| bus_addr_i | input | ADDR_W | Word address |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data for bus_addr_i |
| sck_o | output | 1 | Serial clock |
| mosi_o | output | 1 | Serial data out |
| miso_i | input | 1 | Serial data in |
| cs_n_o | output | CS_N | Peripheral selects, active low |
| irq_o | output | 1 | Done interrupt request |

## Verification
Completion of the last slot and a software clear of STATUS can land on the same clock edge. The bench computes the finish edge from N*(1+16*DIV) and times the clear write to be captured on exactly that edge. It then requires done to remain 1 with the interrupt still asserted. A second overlap is a start request issued in the middle of a run. That case is judged by the done bit rising at the unchanged predicted cycle and by the count of bytes the peripheral model saw.

// File: rtl/slotq_pkg.sv
package slotq_pkg;
  typedef enum logic [1:0] {SQ_IDLE, SQ_LOAD, SQ_SHIFT} sq_state_e;
  localparam int unsigned CTRL_CONT_BIT  = 7;
  localparam int unsigned CTRL_START_BIT = 6;
  localparam int unsigned CTRL_IRQ_BIT   = 5;
  localparam int unsigned CMD_CONT_BIT   = 7;
endpackage

// File: rtl/slotq_ram.sv
module slotq_ram #(
  parameter int unsigned DEPTH = 32,
  parameter int unsigned W     = 8,
  parameter int unsigned NRD   = 2,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   we_i,
  input  logic [AW-1:0]          waddr_i,
  input  logic [W-1:0]           wdata_i,
  input  logic [NRD-1:0][AW-1:0] raddr_i,
  output logic [NRD-1:0][W-1:0]  rdata_o
);
  logic [W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (we_i) begin
      mem_q[waddr_i] <= wdata_i;
    end
  end

  for (genvar g = 0; g < NRD; g++) begin : g_rd
    assign rdata_o[g] = mem_q[raddr_i[g]];
  end
endmodule

// File: rtl/slotq_shifter.sv
module slotq_shifter #(
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             go_i,
  input  logic [DIV_W-1:0] div_i,
  input  logic [7:0]       tx_i,
  input  logic             miso_i,
  output logic             sck_o,
  output logic             mosi_o,
  output logic             done_o,
  output logic [7:0]       rx_o
);
  logic             busy_q, sck_q, mosi_q;
  logic [DIV_W-1:0] cnt_q;
  logic [2:0]       bit_q;
  logic [7:0]       tx_sh_q, rx_sh_q;
  logic             tick;

  assign tick   = busy_q && (cnt_q == '0);
  assign done_o = tick && !sck_q && (bit_q == 3'd7);
  assign rx_o   = {rx_sh_q[6:0], miso_i};
  assign sck_o  = sck_q;
  assign mosi_o = mosi_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      sck_q   <= 1'b1;
      mosi_q  <= 1'b1;
      cnt_q   <= '0;
      bit_q   <= '0;
      tx_sh_q <= '0;
      rx_sh_q <= '0;
    end else if (go_i) begin
      busy_q  <= 1'b1;
      sck_q   <= 1'b1;
      cnt_q   <= div_i - 1'b1;
      bit_q   <= '0;
      tx_sh_q <= tx_i;
    end else if (tick) begin
      cnt_q <= div_i - 1'b1;
      if (sck_q) begin
        // falling edge: present next bit
        sck_q   <= 1'b0;
        mosi_q  <= tx_sh_q[7];
        tx_sh_q <= {tx_sh_q[6:0], 1'b0};
      end else begin
        // rising edge: sample
        sck_q   <= 1'b1;
        rx_sh_q <= rx_o;
        bit_q   <= bit_q + 1'b1;
        if (bit_q == 3'd7) busy_q <= 1'b0;
      end
    end else if (busy_q) begin
      cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/slotq_spi_master.sv
module slotq_spi_master
  import slotq_pkg::*;
#(
  parameter int unsigned SLOTS   = 16,
  parameter int unsigned DIV_W   = 8,
  parameter int unsigned DIV_MIN = 8,
  parameter int unsigned CS_N    = 4,
  parameter int unsigned ADDR_W  = 7
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              bus_req_i,
  input  logic              bus_we_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic [7:0]        bus_wdata_i,
  output logic [7:0]        bus_rdata_o,
  output logic              sck_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [CS_N-1:0]   cs_n_o,
  output logic              irq_o
);
  localparam int unsigned SLOT_W = $clog2(SLOTS);
  localparam int unsigned WORDS  = 2 * SLOTS;
  localparam int unsigned WORD_W = SLOT_W + 1;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_QST  = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_QEND = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_DIV  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(5);
  localparam logic [ADDR_W-1:0] A_LOCK = ADDR_W'(6);
  localparam logic [ADDR_W-1:0] A_TX   = ADDR_W'(WORDS);
  localparam logic [ADDR_W-1:0] A_RX   = ADDR_W'(2 * WORDS);
  localparam logic [ADDR_W-1:0] A_CMD  = ADDR_W'(3 * WORDS);
  localparam logic [ADDR_W-1:0] A_END  = ADDR_W'(3 * WORDS + SLOTS);

  sq_state_e          state_q;
  logic [SLOT_W-1:0]  slot_q, qstart_q, qend_q;
  logic [DIV_W-1:0]   div_q;
  logic [5:0]         mode_q;
  logic               irq_en_q, cont_q, start_q, done_q, lock_q;
  logic [CS_N-1:0]    cs_n_q;

  logic wr, ctrl_wr, start_req, seq_idle, slot_done, last_slot, fin;
  logic in_tx, in_rx, in_cmd;
  logic [ADDR_W-1:0] off_tx, off_rx, off_cmd;
  logic [1:0][7:0] tx_rd, cmd_rd;
  logic [0:0][7:0] rx_rd;
  logic [7:0] rx_byte, cmd_eng;
  logic       sh_go;
  logic       unused_cmd;

  assign wr        = bus_req_i && bus_we_i;
  assign ctrl_wr   = wr && (bus_addr_i == A_CTRL);
  assign seq_idle  = (state_q == SQ_IDLE);
  assign start_req = ctrl_wr && bus_wdata_i[CTRL_START_BIT] && seq_idle;
  assign last_slot = (slot_q == qend_q);
  assign fin       = slot_done && last_slot;
  assign sh_go     = (state_q == SQ_LOAD);
  assign cmd_eng   = cmd_rd[1];
  assign unused_cmd = ^cmd_eng[6:CS_N];

  assign in_tx   = (bus_addr_i >= A_TX)  && (bus_addr_i < A_RX);
  assign in_rx   = (bus_addr_i >= A_RX)  && (bus_addr_i < A_CMD);
  assign in_cmd  = (bus_addr_i >= A_CMD) && (bus_addr_i < A_END);
  assign off_tx  = bus_addr_i - A_TX;
  assign off_rx  = bus_addr_i - A_RX;
  assign off_cmd = bus_addr_i - A_CMD;

  slotq_ram #(.DEPTH(WORDS), .W(8), .NRD(2)) u_tx_ram (
    .clk_i, .rst_ni,
    .we_i   (wr && in_tx),
    .waddr_i(off_tx[WORD_W-1:0]),
    .wdata_i(bus_wdata_i),
    .raddr_i({{slot_q, 1'b0}, off_tx[WORD_W-1:0]}),
    .rdata_o(tx_rd)
  );

  slotq_ram #(.DEPTH(SLOTS), .W(8), .NRD(2)) u_cmd_ram (
    .clk_i, .rst_ni,
    .we_i   (wr && in_cmd),
    .waddr_i(off_cmd[SLOT_W-1:0]),
    .wdata_i(bus_wdata_i),
    .raddr_i({slot_q, off_cmd[SLOT_W-1:0]}),
    .rdata_o(cmd_rd)
  );

  slotq_ram #(.DEPTH(WORDS), .W(8), .NRD(1)) u_rx_ram (
    .clk_i, .rst_ni,
    .we_i   (slot_done),
    .waddr_i({slot_q, 1'b1}),
    .wdata_i(rx_byte),
    .raddr_i(off_rx[WORD_W-1:0]),
    .rdata_o(rx_rd)
  );

  slotq_shifter #(.DIV_W(DIV_W)) u_shift (
    .clk_i, .rst_ni,
    .go_i  (sh_go),
    .div_i (div_q),
    .tx_i  (tx_rd[1]),
    .miso_i,
    .sck_o,
    .mosi_o,
    .done_o(slot_done),
    .rx_o  (rx_byte)
  );

  // registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_en_q <= 1'b0;
      cont_q   <= 1'b0;
      start_q  <= 1'b0;
      done_q   <= 1'b0;
      qstart_q <= '0;
      qend_q   <= '0;
      div_q    <= DIV_W'(DIV_MIN);
      mode_q   <= '0;
      lock_q   <= 1'b0;
    end else begin
      if (ctrl_wr) begin
        irq_en_q <= bus_wdata_i[CTRL_IRQ_BIT];
        cont_q   <= bus_wdata_i[CTRL_CONT_BIT];
      end
      if (start_req)  start_q <= 1'b1;
      else if (fin)   start_q <= 1'b0;
      // completion wins over a same-edge clear
      if (fin) done_q <= 1'b1;
      else if (wr && bus_addr_i == A_STAT && !bus_wdata_i[0]) done_q <= 1'b0;
      if (wr && bus_addr_i == A_QST)  qstart_q <= bus_wdata_i[SLOT_W-1:0];
      if (wr && bus_addr_i == A_QEND) qend_q   <= bus_wdata_i[SLOT_W-1:0];
      if (wr && bus_addr_i == A_DIV)
        div_q <= (bus_wdata_i < 8'(DIV_MIN)) ? DIV_W'(DIV_MIN) : DIV_W'(bus_wdata_i);
      if (wr && bus_addr_i == A_MODE) mode_q <= bus_wdata_i[5:0];
      if (wr && bus_addr_i == A_LOCK) lock_q <= bus_wdata_i[0];
    end
  end

  // slot sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      slot_q  <= '0;
      cs_n_q  <= '1;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (start_req) begin
          state_q <= SQ_LOAD;
          slot_q  <= qstart_q;
        end
        SQ_LOAD: begin
          state_q <= SQ_SHIFT;
          cs_n_q  <= cmd_eng[CS_N-1:0];
        end
        SQ_SHIFT: if (slot_done) begin
          if (!cmd_eng[CMD_CONT_BIT]) cs_n_q <= '1;
          if (last_slot) state_q <= SQ_IDLE;
          else begin
            state_q <= SQ_LOAD;
            slot_q  <= (slot_q == SLOT_W'(SLOTS - 1)) ? '0 : slot_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  always_comb begin
    bus_rdata_o = '0;
    if (bus_addr_i == A_CTRL)      bus_rdata_o = {cont_q, start_q, irq_en_q, 5'b0};
    else if (bus_addr_i == A_STAT) bus_rdata_o = {7'b0, done_q};
    else if (bus_addr_i == A_QST)  bus_rdata_o = 8'(qstart_q);
    else if (bus_addr_i == A_QEND) bus_rdata_o = 8'(qend_q);
    else if (bus_addr_i == A_DIV)  bus_rdata_o = 8'(div_q);
    else if (bus_addr_i == A_MODE) bus_rdata_o = {2'b0, mode_q};
    else if (bus_addr_i == A_LOCK) bus_rdata_o = {7'b0, lock_q};
    else if (in_tx)                bus_rdata_o = tx_rd[0];
    else if (in_rx)                bus_rdata_o = rx_rd[0];
    else if (in_cmd)               bus_rdata_o = cmd_rd[0];
  end

  assign cs_n_o = cs_n_q;
  assign irq_o  = done_q && irq_en_q;
endmodule

// File: rtl/slotq_spi_chk.sv
module slotq_spi_chk #(
  parameter int unsigned CS_N = 4
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            sck_o,
  input logic            mosi_o,
  input logic [CS_N-1:0] cs_n_o,
  input logic            seq_idle,
  input logic            slot_done,
  input logic            cmd_cont,
  input logic            fin,
  input logic            done_q,
  input logic            start_q
);
  // R3: clock parked high outside a run
  p_sck_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    seq_idle |-> sck_o);

  // R3: data moves only at a falling clock edge
  p_mosi_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sck_o && $past(sck_o)) |-> $stable(mosi_o));

  // R5: cleared continue bit releases every select
  p_cs_release_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (slot_done && !cmd_cont) |=> (&cs_n_o));

  // R6: last slot sets done and drops start
  p_done_set_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fin |=> (done_q && !start_q));

  // R9: start bit holds for the whole run
  p_start_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !seq_idle |-> start_q);
endmodule

bind slotq_spi_master slotq_spi_chk #(.CS_N(CS_N)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .sck_o    (sck_o),
  .mosi_o   (mosi_o),
  .cs_n_o   (cs_n_o),
  .seq_idle (seq_idle),
  .slot_done(slot_done),
  .cmd_cont (cmd_eng[7]),
  .fin      (fin),
  .done_q   (done_q),
  .start_q  (start_q)
);

// File: tb/slotq_spi_master_tb_top.sv
module slotq_spi_master_tb_top;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0, rst_n = 1'b0;
  logic       req = 1'b0, we = 1'b0;
  logic [6:0] addr = '0;
  logic [7:0] wdata = '0, rdata;
  logic       sck, mosi, miso = 1'b1, irq;
  logic [3:0] cs_n;

  int checks = 0, fails = 0;
  bit finished = 0;

  slotq_spi_master dut_i (
    .clk_i(clk), .rst_ni(rst_n), .bus_req_i(req), .bus_we_i(we),
    .bus_addr_i(addr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .sck_o(sck), .mosi_o(mosi), .miso_i(miso), .cs_n_o(cs_n), .irq_o(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // peripheral model
  int cyc = 0, fall_prev = 0, fall_last = 0, bitpos = 0, nbytes = 0, cs_rel = 0;
  logic [7:0] mosi_acc = '0;
  logic [7:0] mosi_log [64];
  logic [3:0] cs_log [64];
  wire cs_all_hi = &cs_n;

  function automatic logic [7:0] pat(input int k);
    return 8'h3C + 8'(29 * k);
  endfunction

  always @(posedge clk) cyc++;

  always @(negedge sck) if (rst_n) begin
    logic [7:0] b;
    b = pat(nbytes);
    miso <= b[7 - bitpos];
    fall_prev = fall_last;
    fall_last = cyc;
  end

  always @(posedge sck) if (rst_n) begin
    if (bitpos == 0) cs_log[nbytes] = cs_n;
    mosi_acc = {mosi_acc[6:0], mosi};
    if (bitpos == 7) begin
      mosi_log[nbytes] = mosi_acc;
      nbytes++;
      bitpos = 0;
    end else bitpos++;
  end

  always @(posedge cs_all_hi) if (rst_n) cs_rel++;

  task automatic chk(input string r, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", r, act, exp);
    end
  endtask

  task automatic bus_write(input int a, input int d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = 7'(a); wdata = 8'(d);
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic bus_read(input int a, output int d);
    addr = 7'(a);
    #1;
    d = int'(rdata);
  endtask

  task automatic wait_neg(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, base, t, rel0;
    wait_neg(4);
    rst_n = 1'b1;
    wait_neg(1);

    // R1 reset state
    chk("R1 sck", int'(sck), 1);
    chk("R1 cs_n", int'(cs_n), 'hF);
    chk("R1 irq", int'(irq), 0);
    bus_read(0, v); chk("R1 ctrl", v, 0);
    bus_read(1, v); chk("R1 status", v, 0);
    bus_read(3, v); chk("R1 qend", v, 0);
    bus_read(4, v); chk("R1 div", v, 8);

    // R2 divider clamp
    bus_write(4, 3);  bus_read(4, v); chk("R2 div clamp", v, 8);
    bus_write(4, 10); bus_read(4, v); chk("R2 div store", v, 10);
    bus_write(4, 8);

    // R10 lock and mode storage
    bus_write(6, 1);    bus_read(6, v); chk("R10 lock", v, 1);
    bus_write(5, 'h23); bus_read(5, v); chk("R10 mode", v, 'h23);

    // Run A: slots 0..3, div 8, irq on
    for (int s = 0; s < 4; s++) begin
      bus_write('h20 + 2 * s, 'hA1 + 17 * s);
      bus_write('h60 + s, (s == 3) ? 'h0E : 'h8E);
    end
    bus_write(2, 0); bus_write(3, 3);
    base = nbytes;
    t = 4 * (1 + 16 * 8);
    bus_write(0, 'h60);
    bus_read(0, v); chk("R6 start reads 1", (v >> 6) & 1, 1);
    wait_neg(t - 1);
    bus_read(1, v); chk("R6 done not early", v, 0);
    wait_neg(1);
    bus_read(1, v); chk("R6 done on time", v, 1);
    bus_read(0, v); chk("R6 start cleared", (v >> 6) & 1, 0);
    chk("R8 irq on", int'(irq), 1);
    chk("R5 cs released at end", int'(cs_n), 'hF);
    chk("R3 sck period", fall_last - fall_prev, 16);
    chk("R3 idle high", int'(sck), 1);
    for (int s = 0; s < 4; s++) begin
      chk("R3 mosi msb first", int'(mosi_log[base + s]), ('hA1 + 17 * s) & 'hFF);
      chk("R5 cs pattern", int'(cs_log[base + s]), 'hE);
      bus_read('h40 + 2 * s + 1, v);
      chk("R4 rx word", v, int'(pat(base + s)));
    end
    bus_read('h40, v); chk("R4 even rx untouched", v, 0);

    // R7 clear
    bus_write(1, 0);
    bus_read(1, v); chk("R7 clear", v, 0);
    chk("R8 irq off after clear", int'(irq), 0);

    // Run B: wrap 14..1, div 10, irq off, restart attempt mid-run
    bus_write(4, 10);
    bus_write('h20 + 28, 'h81); bus_write('h6E, 'h0D);
    bus_write('h20 + 30, 'h42); bus_write('h6F, 'h8B);
    bus_write('h20 + 0,  'h18); bus_write('h60, 'h87);
    bus_write('h20 + 2,  'hE7); bus_write('h61, 'h0E);
    bus_write(2, 14); bus_write(3, 1);
    base = nbytes; rel0 = cs_rel;
    t = 4 * (1 + 16 * 10);
    bus_write(0, 'h40);
    wait_neg(200);
    bus_write(0, 'h40);               // R9 ignored request
    wait_neg(t - 1 - 202);
    bus_read(1, v); chk("R9 no change to run length (early)", v, 0);
    wait_neg(1);
    bus_read(1, v); chk("R9 done on original schedule", v, 1);
    chk("R9 byte count", nbytes - base, 4);
    chk("R8 irq masked", int'(irq), 0);
    chk("R3 sck period div10", fall_last - fall_prev, 20);
    chk("R5 cs slot14", int'(cs_log[base]), 'hD);
    chk("R5 cs slot15", int'(cs_log[base + 1]), 'hB);
    chk("R5 cs slot0", int'(cs_log[base + 2]), 'h7);
    chk("R5 cs slot1", int'(cs_log[base + 3]), 'hE);
    chk("R5 release count", cs_rel - rel0, 2);
    chk("R4 wrap tx slot0", int'(mosi_log[base + 2]), 'h18);
    bus_read('h40 + 29, v); chk("R4 rx slot14", v, int'(pat(base)));
    bus_read('h40 + 3, v);  chk("R4 rx slot1", v, int'(pat(base + 3)));
    bus_write(1, 0);

    // Run C: single slot with continue, clear collides with completion
    bus_write(4, 8);
    bus_write('h20 + 10, 'h5A); bus_write('h65, 'h8E);
    bus_write(2, 5); bus_write(3, 5);
    base = nbytes;
    t = 1 + 16 * 8;
    bus_write(0, 'h60);
    wait_neg(t - 2);
    bus_write(1, 0);                  // captured on the finishing edge
    bus_read(1, v); chk("R7 set wins over clear", v, 1);
    chk("R7 irq kept", int'(irq), 1);
    chk("R5 cs held by continue", int'(cs_n), 'hE);
    chk("R3 mosi single", int'(mosi_log[base]), 'h5A);
    bus_write(1, 0);
    bus_read(1, v); chk("R7 later clear", v, 0);

    // Run D: release after held select, lock cleared (R10 no effect)
    bus_write(6, 0);
    bus_write('h20 + 12, 'hC3); bus_write('h66, 'h0E);
    bus_write(2, 6); bus_write(3, 6);
    bus_write(0, 'h40);
    wait_neg(t);
    bus_read(1, v); chk("R10 run unaffected by lock", v, 1);
    chk("R5 cs released", int'(cs_n), 'hF);
    bus_read('h40 + 13, v); chk("R4 rx slot6", v, int'(pat(base + 1)));

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule